// File: doc/BRIEF.md
# Filtered Edge Interrupt Flag Controller

This block gathers sixteen interrupt lines that come from programmable logic and presents them to a small processor. Each line is first synchronised, then passed through a stability filter. The filter accepts a high-to-low change only when the line was high for two samples before the change and low for two samples after it. An accepted change sets a sticky flag. A flag raises a request when its enable mask and the global interrupt enable are both set. When several requests are pending, the lowest line index is reported.

The processor reaches the flags and masks through four consecutive 8-bit I/O addresses, with four lines per address. An alternate-map control bit selects how those addresses are used. When it is 1, they reach the registers. When it is 0, they become select strobes towards the programmable logic. A flag clears when the processor acknowledges the reported line, or when software writes a 1 to the flag bit.

In the deep sleep modes, lines 0 to 3 become low-level sensitive so that they can wake the processor. A reduced configuration removes lines 8 to 15.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After synchronous reset, every flag and mask reads 0, and `req_o` and `wake_o` are 0.
- R2: Register g (g = 0..3) sits at address `BASE_ADDR + g` and covers lines 4g..4g+3. Bits 7..4 are the flags and bits 3..0 are the masks. Bit 4+b and bit b belong to line 4g+b. While `alt_map_i` is 1 and the address matches, `io_rdata_o` shows that register. Otherwise it is 0.
- R3: A flag sets only when the synchronised line shows two high samples followed by two low samples. The set becomes readable after the fifth rising edge, counting from the edge that first samples the low raw level. A low pulse of one sample, or a high level held for only one sample before the fall, sets nothing.
- R4: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged. A mask write takes effect at the write edge and is visible in the following cycle.
- R5: `req_o` is 1 exactly when some line has its flag, its mask and `gie_i` all set. `req_idx_o` gives the lowest such line.
- R6: A one-cycle `ack_i` while `req_o` is 1 clears the flag of the line shown on `req_idx_o`. An `ack_i` while `req_o` is 0 does nothing.
- R7: When a flag set and a flag clear (write or acknowledge) hit the same line in the same cycle, the flag ends set.
- R8: While `alt_map_i` is 0, a read or write at `BASE_ADDR + g` pulses `sel_o[g]`. Such an access leaves the flags and masks untouched, and `io_rdata_o` is 0. While `alt_map_i` is 1, `sel_o` stays 0.
- R9: While `sleep_i` is 1, a synchronised low level on an enabled line 0..3 drives `wake_o` and sets that line's flag. Lines 4..15 never drive `wake_o`.
- R10: With `FULL_BANK` = 0, the flags and masks of lines 8..15 always read 0, and lines 0..7 behave as normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw_i | input | 16 | Asynchronous interrupt lines from programmable logic |
| gie_i | input | 1 | Global interrupt enable from the processor |
| sleep_i | input | 1 | Processor is in a deep sleep mode |
| alt_map_i | input | 1 | 1: addresses reach the registers; 0: addresses become strobes |
| io_addr_i | input | 6 | I/O address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Register read data |
| sel_o | output | 4 | Select strobes, one per address |
| req_o | output | 1 | Interrupt request |
| req_idx_o | output | 4 | Index of the winning line |
| ack_i | input | 1 | Vector acknowledge pulse |
| wake_o | output | 1 | Wake-up request from lines 0..3 |

## Verification
The delicate overlap is a filter-confirmed edge that lands on the same edge as a write-one-to-clear of the same flag. The bench drops line 9 and counts four falling clock edges. It then holds a write of a 1 to that flag bit across exactly the edge where the filter confirms the fall. Reading the register afterwards must show the flag still set.

A behavioural model checks every cycle, so an acknowledge that collides with a fresh edge on the winning line is judged by the same rule. Set beats clear.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int LINES      = 16;
    localparam int GRP_LINES  = 4;
    localparam int GRPS       = LINES / GRP_LINES;
    localparam int IDX_W      = $clog2(LINES);
    localparam int WAKE_LINES = 4;

    typedef struct packed {
        logic [GRP_LINES-1:0] flags;
        logic [GRP_LINES-1:0] masks;
    } grp_view_t;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_REG  = 2'd1,
        ACC_SEL  = 2'd2
    } acc_kind_t;

    function automatic acc_kind_t classify(input logic hit, input logic alt, input logic access);
        if (!hit || !access) return ACC_IDLE;
        return alt ? ACC_REG : ACC_SEL;
    endfunction

endpackage

// File: rtl/eirq_line_filter.sv
module eirq_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic fall_o
);
    localparam int HIST_W = 2 * HOLD;
    localparam logic [HIST_W-1:0] FALL_PAT = {{HOLD{1'b1}}, {HOLD{1'b0}}};

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST_W-1:0]      hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            hist_q <= {hist_q[HIST_W-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    assign level_o = sync_q[SYNC_STAGES-1];
    assign fall_o  = (hist_q == FALL_PAT);

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst) fall_o |=> !fall_o); // R3

endmodule

// File: rtl/eirq_prio.sv
module eirq_prio #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] pend_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = W'(i);
        end
    end

    always_comb begin
        if (any_o) begin
            AST_WINNER_PENDING: assert (pend_i[idx_o]); // R5
            AST_WINNER_LOWEST: assert ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0); // R5
        end
    end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h14,
    parameter bit                FULL_BANK   = 1'b1,
    parameter int                SYNC_STAGES = 2,
    parameter int                HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  irq_raw_i,
    input  logic              gie_i,
    input  logic              sleep_i,
    input  logic              alt_map_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              io_wr_i,
    input  logic              io_rd_i,
    input  logic [7:0]        io_wdata_i,
    output logic [7:0]        io_rdata_o,
    output logic [GRPS-1:0]   sel_o,
    output logic              req_o,
    output logic [IDX_W-1:0]  req_idx_o,
    input  logic              ack_i,
    output logic              wake_o
);
    localparam int PRESENT = FULL_BANK ? LINES : LINES / 2;

    logic [LINES-1:0] flags_q, masks_q, flags_d, masks_d;
    logic [LINES-1:0] set_v, clr_v, level_v, fall_v, pend_v;
    logic [GRPS-1:0]  grp_hit, reg_wr;
    acc_kind_t        acc [GRPS];
    logic             ack_take;

    // Address decode: register access or select strobe per group
    for (genvar g = 0; g < GRPS; g++) begin : g_dec
        assign grp_hit[g] = (io_addr_i == ADDR_W'(int'(BASE_ADDR) + g));
        assign acc[g]     = classify(grp_hit[g], alt_map_i, io_wr_i | io_rd_i);
        assign reg_wr[g]  = (acc[g] == ACC_REG) && io_wr_i;
        assign sel_o[g]   = (acc[g] == ACC_SEL);
    end

    assign ack_take = ack_i && req_o;

    // Per-line filter, set and clear
    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam int G = i / GRP_LINES;
        localparam int B = i % GRP_LINES;
        if (i < PRESENT) begin : g_on
            eirq_line_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .HOLD       (HOLD_CYCLES)
            ) u_filt (
                .clk    (clk),
                .rst    (rst),
                .raw_i  (irq_raw_i[i]),
                .level_o(level_v[i]),
                .fall_o (fall_v[i])
            );
            assign set_v[i]   = fall_v[i] |
                                ((i < WAKE_LINES) && sleep_i && !level_v[i] && masks_q[i]);
            assign clr_v[i]   = (reg_wr[G] && io_wdata_i[GRP_LINES + B]) ||
                                (ack_take && (req_idx_o == IDX_W'(i)));
            assign flags_d[i] = set_v[i] | (flags_q[i] & ~clr_v[i]);
            assign masks_d[i] = reg_wr[G] ? io_wdata_i[B] : masks_q[i];

            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) set_v[i] |=> flags_q[i]); // R7
        end else begin : g_off
            assign level_v[i] = 1'b1;
            assign fall_v[i]  = 1'b0;
            assign set_v[i]   = 1'b0;
            assign clr_v[i]   = 1'b0;
            assign flags_d[i] = 1'b0;
            assign masks_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            masks_q <= '0;
        end else begin
            flags_q <= flags_d;
            masks_q <= masks_d;
        end
    end

    // Request arbitration
    assign pend_v = flags_q & masks_q & {LINES{gie_i}};

    eirq_prio #(.N(LINES)) u_prio (
        .pend_i(pend_v),
        .any_o (req_o),
        .idx_o (req_idx_o)
    );

    // Wake from low level on the first lines
    assign wake_o = sleep_i && |(~level_v[WAKE_LINES-1:0] & masks_q[WAKE_LINES-1:0]);

    // Register read view
    always_comb begin
        grp_view_t view;
        view       = '0;
        for (int g = 0; g < GRPS; g++) begin
            if (grp_hit[g] && alt_map_i) begin
                view.flags = flags_q[g*GRP_LINES +: GRP_LINES];
                view.masks = masks_q[g*GRP_LINES +: GRP_LINES];
            end
        end
        io_rdata_o = view;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !set_v[req_idx_o]) |=> !flags_q[$past(req_idx_o)]); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(|reg_wr) |=> $stable(masks_q)); // R4
    AST_SEL_NO_TOUCH: assert property (@(posedge clk) disable iff (rst)
        (|sel_o) |=> $stable(masks_q)); // R8

endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
    localparam logic [5:0] BASE = 6'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_raw = 16'hFF7F;
    logic        gie = 1'b0, sleep = 1'b0, alt = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0, ack = 1'b0;
    logic [5:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;

    logic [7:0] rdata, rdata_s;
    logic [3:0] sel, sel_s, idx, idx_s;
    logic       req, req_s, wake, wake_s;

    always #4 clk = ~clk;

    edge_irq_ctrl uut (
        .clk(clk), .rst(rst), .irq_raw_i(irq_raw), .gie_i(gie), .sleep_i(sleep),
        .alt_map_i(alt), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
        .io_wdata_i(io_wdata), .io_rdata_o(rdata), .sel_o(sel), .req_o(req),
        .req_idx_o(idx), .ack_i(ack), .wake_o(wake)
    );

    edge_irq_ctrl #(.FULL_BANK(1'b0)) uut_small (
        .clk(clk), .rst(rst), .irq_raw_i(irq_raw), .gie_i(gie), .sleep_i(sleep),
        .alt_map_i(alt), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
        .io_wdata_i(io_wdata), .io_rdata_o(rdata_s), .sel_o(sel_s), .req_o(req_s),
        .req_idx_o(idx_s), .ack_i(ack), .wake_o(wake_s)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit         m_flag [16];
    bit         m_mask [16];
    logic [5:0] h      [16];

    function automatic int m_winner(output bit any);
        int w = 0;
        any = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (m_flag[i] && m_mask[i] && gie) begin
                any = 1'b1;
                w = i;
            end
        end
        return w;
    endfunction

    always @(posedge clk) begin
        bit nf [16];
        bit nm [16];
        bit any, setb, clrb, hitw;
        int w;
        if (rst) begin
            for (int i = 0; i < 16; i++) begin
                m_flag[i] = 1'b0;
                m_mask[i] = 1'b0;
                h[i] = '0;
            end
        end else begin
            w = m_winner(any);
            for (int i = 0; i < 16; i++) begin
                hitw = io_wr && alt && (int'(io_addr) == int'(BASE) + i / 4);
                setb = (h[i][5] && h[i][4] && !h[i][3] && !h[i][2]) ||
                       (i < 4 && sleep && !h[i][1] && m_mask[i]);
                clrb = (hitw && io_wdata[4 + i % 4]) || (ack && any && w == i);
                nf[i] = setb ? 1'b1 : (clrb ? 1'b0 : m_flag[i]);
                nm[i] = hitw ? io_wdata[i % 4] : m_mask[i];
            end
            for (int i = 0; i < 16; i++) begin
                m_flag[i] = nf[i];
                m_mask[i] = nm[i];
                h[i] = {h[i][4:0], irq_raw[i]};
            end
        end
    end

    // Compare on every cycle
    always @(negedge clk) begin
        bit any;
        int w, exp_rd, exp_sel, exp_wake;
        if (!rst) begin
            w = m_winner(any);
            exp_rd = 0;
            exp_sel = 0;
            exp_wake = 0;
            for (int g = 0; g < 4; g++) begin
                if (int'(io_addr) == int'(BASE) + g) begin
                    if (alt) begin
                        for (int b = 0; b < 4; b++)
                            exp_rd |= (int'(m_flag[4*g+b]) << (4 + b)) | (int'(m_mask[4*g+b]) << b);
                    end else if (io_wr || io_rd) begin
                        exp_sel |= 1 << g;
                    end
                end
            end
            for (int i = 0; i < 4; i++)
                if (sleep && m_mask[i] && !h[i][1]) exp_wake = 1;
            chk("R5 request", int'(req), int'(any));
            if (any) chk("R5 winner index", int'(idx), w);
            chk("R9 wake", int'(wake), exp_wake);
            chk("R8 strobes", int'(sel), exp_sel);
            chk("R2 read data", int'(rdata), exp_rd);
        end
    end

    task automatic wr_reg(input int g, input logic [7:0] d);
        @(negedge clk); #1;
        io_addr = BASE + 6'(g);
        io_wdata = d;
        io_wr = 1'b1;
        @(negedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic drop(input int line);
        @(negedge clk); #1;
        irq_raw[line] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        alt = 1'b1;
        @(negedge clk); #2;
        for (int g = 0; g < 4; g++) begin
            io_addr = BASE + 6'(g);
            #1 chk("R1 reset register", int'(rdata), 0);
        end
        chk("R1 reset request", int'(req), 0);
        chk("R1 reset wake", int'(wake), 0);

        gie = 1'b1;
        for (int g = 0; g < 4; g++) wr_reg(g, 8'h0F);
        repeat (8) @(negedge clk);

        // R3: latency of a clean fall on line 5
        io_addr = BASE + 6'd1;
        drop(5);
        repeat (4) @(negedge clk);
        #2 chk("R3 flag not yet set", int'(rdata), 8'h0F);
        @(negedge clk);
        #2 chk("R3 flag set after filter", int'(rdata), 8'h2F);
        chk("R5 single request index", int'(idx), 5);

        // R3: short pulses
        @(negedge clk); #1 irq_raw[6] = 1'b0;
        @(negedge clk); #1 irq_raw[6] = 1'b1;
        @(negedge clk); #1 irq_raw[7] = 1'b1;
        @(negedge clk); #1 irq_raw[7] = 1'b0;
        repeat (8) @(negedge clk);
        #2 chk("R3 short pulses ignored", int'(rdata), 8'h2F);

        // R5: lowest index wins
        io_addr = BASE;
        drop(2);
        repeat (6) @(negedge clk);
        #2 chk("R5 lowest wins", int'(idx), 2);
        chk("R2 flag field of line 2", int'(rdata), 8'h4F);

        // R6: acknowledge
        @(negedge clk); #1 ack = 1'b1;
        @(negedge clk); #1 ack = 1'b0;
        #1 chk("R6 ack cleared line 2", int'(rdata), 8'h0F);
        chk("R6 next winner", int'(idx), 5);

        // R4: write zero keeps, write one clears
        wr_reg(1, 8'h0F);
        #1 chk("R4 write zero no effect", int'(rdata), 8'h2F);
        wr_reg(1, 8'h2F);
        #1 chk("R4 write one clears", int'(rdata), 8'h0F);
        chk("R4 no request left", int'(req), 0);
        wr_reg(1, 8'h00);
        #1 chk("R4 mask write visible", int'(rdata), 8'h00);
        wr_reg(1, 8'h0F);

        // R7: set beats a same-cycle clear on line 9
        io_addr = BASE + 6'd2;
        drop(9);
        repeat (4) @(negedge clk);
        #1 io_wdata = 8'h2F; io_wr = 1'b1;
        @(negedge clk); #1 io_wr = 1'b0;
        #1 chk("R7 set beats clear", int'(rdata), 8'h2F);
        chk("R5 request from line 9", int'(idx), 9);
        gie = 1'b0;
        #1 chk("R5 global enable off", int'(req), 0);
        gie = 1'b1;

        // R10: reduced configuration
        #1 chk("R10 group 2 absent", int'(rdata_s), 0);
        io_addr = BASE + 6'd3;
        #1 chk("R10 group 3 absent", int'(rdata_s), 0);
        io_addr = BASE + 6'd1;
        #1 chk("R10 group 1 present", int'(rdata_s), 8'h0F);

        // R8: strobe mode
        @(negedge clk); #1;
        alt = 1'b0; io_addr = BASE; io_wdata = 8'hFF; io_wr = 1'b1;
        #1 chk("R8 strobe on group 0", int'(sel), 1);
        chk("R8 read data zero", int'(rdata), 0);
        @(negedge clk); #1 io_wr = 1'b0; alt = 1'b1;
        #1 chk("R8 register untouched", int'(rdata), 8'h0F);

        // R9: deep sleep
        for (int g = 0; g < 4; g++) wr_reg(g, 8'hFF);
        @(negedge clk); #1 irq_raw = 16'hFFFF;
        repeat (8) @(negedge clk);
        #1 sleep = 1'b1;
        drop(4);
        repeat (6) @(negedge clk);
        #2 chk("R9 line 4 no wake", int'(wake), 0);
        io_addr = BASE;
        drop(1);
        @(negedge clk);
        #2 chk("R9 wake not before sync", int'(wake), 0);
        @(negedge clk);
        #2 chk("R9 wake from line 1", int'(wake), 1);
        @(negedge clk);
        #2 chk("R9 level flag set", int'(rdata), 8'h2F);

        sleep = 1'b0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule